// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the bus-facing engine of an I2C master. A processor-side port writes an eight-bit control word holding five one-shot command bits: bus start, repeated start, stop, receive one byte, and send an acknowledge bit. Writing the data buffer launches a byte transmission. Each accepted command drives the open-drain SCL and SDA lines through the matching bus sequence, and the command bit clears itself when that sequence is finished.

The SCL timing is fixed by the `DIV` parameter. Every bus sequence is split into units of four quarters, and each quarter lasts `DIV` system clocks. The engine does not queue commands. While it is busy, it refuses any new command bit and any buffer write, and reports each refusal with a one-cycle collision pulse. A one-cycle interrupt pulse marks the end of every sequence. A separate one-cycle pulse flags a received all-zero byte when general-call detection is enabled.

The bus pins are modelled as pull-low enables. A 1 on `scl_oe` or `sda_oe` means the line is driven low. The line reads high when no one pulls it low.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, all of the following read 0: the control word, the buffer, both pull-low enables, `irq`, `wcol`, `rx_full` and `gc_hit`.
- R2: A start command (control bit 0) runs one unit: SCL and SDA released for quarters 0 and 1, SDA low with SCL released in quarter 2, both low in quarter 3. Each quarter lasts `DIV` clocks counted from the accepting edge, and both lines stay low afterwards.
- R3: A repeated start (control bit 1) runs one unit with {SCL,SDA} levels low/high, high/high, high/low, low/low in quarters 0 to 3.
- R4: A stop (control bit 2) runs one unit with levels low/low, high/low, high/high, high/high, and leaves both lines released.
- R5: An accepted buffer write sends 9 bit units. Bits 7 down to 0 of the byte go out on SDA in that order, and SDA is released for the ninth unit. SCL is low in quarters 0 and 3 and released in quarters 1 and 2. SDA is sampled at the end of quarter 1 of the ninth unit into control bit 6 (1 = no acknowledge).
- R6: A receive (control bit 3) runs 8 bit units with SDA released and samples SDA at the end of quarter 1 of each unit, MSB first. At the end, the byte goes to the buffer and `rx_full` is set. `rx_full` clears on the next accepted command or buffer write.
- R7: An acknowledge sequence (control bit 4) runs one bit unit whose SDA value is bit 5 of the same control write: 0 pulls SDA low (ACK), 1 releases it (NACK).
- R8: A launched command bit reads 1 in the control word for the whole sequence, and the edge that ends the sequence clears it.
- R9: While a sequence runs, command bits and buffer writes are ignored and `wcol` pulses for one cycle. A buffer write in the same cycle as an accepted command is also rejected.
- R10: If one write sets several command bits while idle, only the lowest-numbered bit is launched and shown.
- R11: `irq` pulses for exactly one cycle, one clock after the edge that ends any sequence.
- R12: When control bit 7 is 1 and a received byte equals 0x00, `gc_hit` pulses together with `irq`.
- R13: Control bits 7 and 5 take the written value on every control write, busy or not. Bit 6 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Data buffer write data |
| sda_i | input | 1 | Sensed SDA line level |
| ctrl_q | output | 8 | Control word: {gc enable, ack status, ack value, ack seq, receive, stop, rep start, start} |
| buf_q | output | 8 | Data buffer contents |
| rx_full | output | 1 | Received byte waiting in buffer |
| irq | output | 1 | Sequence-complete pulse |
| wcol | output | 1 | Rejected-write pulse |
| gc_hit | output | 1 | All-zero byte received with detection enabled |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The transmit path is tried with 0xA5 and 0x3C. 0xA5 alternates bits, which exposes bit-order or shift-timing slips. 0x3C has runs of equal bits, which catches SDA toggling when it should hold. One transfer ends with an acknowledging slave and one with a silent slave, so the ack-status polarity is pinned in both directions. Receives use 0x5B, which shows bit order, and 0x00, which alone must raise the general-call pulse. Writes issued mid-sequence, several command bits in one write, and a command issued together with a buffer write separate the rejection rule from the priority rule.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int BYTE_BITS = 8;
  localparam int UNIT_W    = 4;

  typedef enum logic [2:0] {
    OP_IDLE, OP_START, OP_RSTART, OP_STOP, OP_TX, OP_RX, OP_ACK
  } op_e;

  // {scl, sda} levels for one quarter of a unit
  function automatic logic [1:0] phase_lv(op_e op, logic [1:0] q, logic b);
    logic [1:0] lv;
    case (op)
      OP_START:  lv = (q == 2'd2) ? 2'b10 : (q == 2'd3) ? 2'b00 : 2'b11;
      OP_RSTART: lv = (q == 2'd0) ? 2'b01 : (q == 2'd1) ? 2'b11 :
                      (q == 2'd2) ? 2'b10 : 2'b00;
      OP_STOP:   lv = (q == 2'd0) ? 2'b00 : (q == 2'd1) ? 2'b10 : 2'b11;
      OP_TX, OP_RX, OP_ACK:
                 lv = {(q == 2'd1) || (q == 2'd2), b};
      default:   lv = 2'b11;
    endcase
    return lv;
  endfunction

  function automatic logic [UNIT_W-1:0] unit_count(op_e op);
    case (op)
      OP_TX:   return UNIT_W'(BYTE_BITS + 1);
      OP_RX:   return UNIT_W'(BYTE_BITS);
      default: return UNIT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_shifter.sv
module i2c_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         msb
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= ld_data;
    else if (shift)  q <= {q[W-2:0], sin};
  end

  assign msb = q[W-1];
endmodule

// File: rtl/i2c_seq.sv
module i2c_seq
  import i2c_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  op_e  launch_op,
  input  logic launch_bit,
  input  logic tick,
  input  logic bit_tx,
  output logic busy,
  output op_e  op,
  output logic done,
  output logic tx_shift,
  output logic rx_sample,
  output logic ack_sample,
  output logic scl_lvl,
  output logic sda_lvl
);
  logic [1:0]        qtr_q;
  logic [UNIT_W-1:0] bidx_q;
  logic              ackbit_q;
  logic [1:0]        hold_q;
  logic              last_unit, cur_b, tx_op, ninth;
  logic [1:0]        lv;

  assign busy      = (op != OP_IDLE);
  assign tx_op     = (op == OP_TX);
  assign ninth     = (bidx_q == UNIT_W'(BYTE_BITS));
  assign last_unit = (bidx_q == unit_count(op) - UNIT_W'(1));
  assign cur_b     = tx_op ? (ninth ? 1'b1 : bit_tx) :
                     (op == OP_ACK) ? ackbit_q : 1'b1;
  assign lv        = phase_lv(op, qtr_q, cur_b);
  assign {scl_lvl, sda_lvl} = busy ? lv : hold_q;

  assign done       = busy && tick && (qtr_q == 2'd3) && last_unit;
  assign tx_shift   = tx_op && tick && (qtr_q == 2'd3) && !ninth;
  assign rx_sample  = (op == OP_RX) && tick && (qtr_q == 2'd1);
  assign ack_sample = tx_op && tick && (qtr_q == 2'd1) && ninth;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op       <= OP_IDLE;
      qtr_q    <= '0;
      bidx_q   <= '0;
      ackbit_q <= 1'b1;
      hold_q   <= 2'b11;
    end else if (launch && !busy) begin
      op       <= launch_op;
      qtr_q    <= '0;
      bidx_q   <= '0;
      ackbit_q <= launch_bit;
    end else if (busy && tick) begin
      if (qtr_q == 2'd3) begin
        qtr_q <= '0;
        if (last_unit) begin
          op     <= OP_IDLE;
          hold_q <= lv;
        end else begin
          bidx_q <= bidx_q + 1'b1;
        end
      end else begin
        qtr_q <= qtr_q + 1'b1;
      end
    end
  end

  // R2
  qtr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(qtr_q));

  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && scl_lvl && $past(scl_lvl) &&
     (op == OP_TX || op == OP_RX || op == OP_ACK)) |-> $stable(sda_lvl));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int DIV = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       buf_wr,
  input  logic [7:0] buf_wdata,
  input  logic       sda_i,
  output logic [7:0] ctrl_q,
  output logic [7:0] buf_q,
  output logic       rx_full,
  output logic       irq,
  output logic       wcol,
  output logic       gc_hit,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int NCMD = 5;

  logic [NCMD-1:0]      cmd_q, cmd_req_bits, pick;
  logic                 gcen_q, ackdt_q, ackstat_q;
  logic                 busy, done, tick, tx_shift, rx_sample, ack_sample;
  logic                 scl_lvl, sda_lvl, bit_tx;
  logic                 cmd_req, cmd_go, buf_go, launch, reject;
  logic [BYTE_BITS-1:0] sh_q;
  op_e                  op, cmd_op, launch_op;
  logic                 unused_ro;

  assign unused_ro    = ctrl_wdata[6];
  assign cmd_req_bits = ctrl_wdata[NCMD-1:0];
  assign cmd_req      = ctrl_wr && (|cmd_req_bits);
  assign cmd_go       = cmd_req && !busy;
  assign buf_go       = buf_wr && !busy && !cmd_req;
  assign launch       = cmd_go || buf_go;
  assign reject       = (cmd_req && busy) || (buf_wr && !buf_go);
  assign pick         = cmd_req_bits & (~cmd_req_bits + 1'b1);

  always_comb begin
    case (pick)
      5'b00001: cmd_op = OP_START;
      5'b00010: cmd_op = OP_RSTART;
      5'b00100: cmd_op = OP_STOP;
      5'b01000: cmd_op = OP_RX;
      5'b10000: cmd_op = OP_ACK;
      default:  cmd_op = OP_IDLE;
    endcase
  end
  assign launch_op = cmd_go ? cmd_op : OP_TX;

  i2c_qtick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  i2c_shifter #(.W(BYTE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(buf_go), .ld_data(buf_wdata),
    .shift(tx_shift || rx_sample), .sin(rx_sample ? sda_i : 1'b0),
    .q(sh_q), .msb(bit_tx)
  );

  i2c_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .launch_bit(ctrl_wdata[5]), .tick(tick), .bit_tx(bit_tx),
    .busy(busy), .op(op), .done(done), .tx_shift(tx_shift),
    .rx_sample(rx_sample), .ack_sample(ack_sample),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      gcen_q    <= 1'b0;
      ackdt_q   <= 1'b0;
      ackstat_q <= 1'b0;
      buf_q     <= '0;
      rx_full   <= 1'b0;
      irq       <= 1'b0;
      wcol      <= 1'b0;
      gc_hit    <= 1'b0;
    end else begin
      irq    <= done;
      wcol   <= reject;
      gc_hit <= done && (op == OP_RX) && gcen_q && (sh_q == '0);
      if (ctrl_wr) begin
        gcen_q  <= ctrl_wdata[7];
        ackdt_q <= ctrl_wdata[5];
      end
      if (ack_sample) ackstat_q <= sda_i;
      if (done) cmd_q <= '0;
      else if (cmd_go) cmd_q <= pick;
      if (launch) rx_full <= 1'b0;
      if (buf_go) buf_q <= buf_wdata;
      if (done && (op == OP_RX)) begin
        buf_q   <= sh_q;
        rx_full <= 1'b1;
      end
    end
  end

  assign ctrl_q = {gcen_q, ackstat_q, ackdt_q, cmd_q};
  assign scl_oe = !scl_lvl;
  assign sda_oe = !sda_lvl;

  // R8
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ctrl_q[NCMD-1:0] == '0));

  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> ((ctrl_q[NCMD-1:0] & ~$past(ctrl_q[NCMD-1:0])) == '0));

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_STOP) |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb_top;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0, buf_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0, buf_wdata = '0;
  logic       sda_drv = 1'b1;
  logic [7:0] ctrl_q, buf_q;
  logic       rx_full, irq, wcol, gc_hit, scl_oe, sda_oe;

  always #4 clk = ~clk;

  i2c_cmd_master #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .sda_i(sda_drv),
    .ctrl_q(ctrl_q), .buf_q(buf_q), .rx_full(rx_full), .irq(irq),
    .wcol(wcol), .gc_hit(gc_hit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_cmp = 0, n_bad = 0, irq_seen = 0, gc_seen = 0;
  int slv_byte = 0, slv_ack_low = 0;

  // reference model state (op: 0 idle,1 start,2 rstart,3 stop,4 tx,5 rx,6 ack)
  int m_op, m_q, m_bit, m_cnt, m_tx, m_rx, m_ackb, m_hold;
  int m_cmd, m_gcen, m_ackdt, m_ackst, m_buf, m_rxf, m_irq, m_wcol, m_gc;

  function automatic int lvl(int op, int q, int b);
    case (op)
      1: return (q == 2) ? 2 : (q == 3) ? 0 : 3;
      2: return (q == 0) ? 1 : (q == 1) ? 3 : (q == 2) ? 2 : 0;
      3: return (q == 0) ? 0 : (q == 1) ? 2 : 3;
      4, 5, 6: return ((q == 1 || q == 2) ? 2 : 0) + b;
      default: return 3;
    endcase
  endfunction

  function automatic int units(int op);
    return (op == 4) ? 9 : (op == 5) ? 8 : 1;
  endfunction

  function automatic int cur_bit();
    if (m_op == 4) return (m_bit == 8) ? 1 : ((m_tx >> (7 - m_bit)) & 1);
    if (m_op == 6) return m_ackb;
    return 1;
  endfunction

  function automatic string bus_tag(int op);
    case (op)
      1: return "R2"; 2: return "R3"; 4: return "R5";
      5: return "R6"; 6: return "R7"; default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    int busy, tick, done, rej, pick, wd, b, l;
    if (!rst_n) begin
      m_op = 0; m_q = 0; m_bit = 0; m_cnt = 0; m_tx = 0; m_rx = 0; m_ackb = 1;
      m_hold = 3; m_cmd = 0; m_gcen = 0; m_ackdt = 0; m_ackst = 0; m_buf = 0;
      m_rxf = 0; m_irq = 0; m_wcol = 0; m_gc = 0;
    end else begin
      busy = (m_op != 0);
      tick = busy && (m_cnt == DIV - 1);
      done = 0; rej = 0; m_gc = 0;
      m_cnt = (!busy || tick) ? 0 : m_cnt + 1;
      if (tick) begin
        if (m_q == 1 && m_op == 4 && m_bit == 8) m_ackst = sda_drv;
        if (m_q == 1 && m_op == 5) m_rx = ((m_rx << 1) | sda_drv) & 255;
        if (m_q == 3) begin
          if (m_bit == units(m_op) - 1) begin
            done = 1;
            b = cur_bit();
            m_hold = lvl(m_op, 3, b);
            if (m_op == 5) begin
              m_buf = m_rx; m_rxf = 1; m_gc = (m_gcen && m_rx == 0);
            end
            m_cmd = 0; m_op = 0;
          end else m_bit++;
          m_q = 0;
        end else m_q++;
      end
      wd = ctrl_wdata;
      if (ctrl_wr) begin
        m_gcen = (wd >> 7) & 1; m_ackdt = (wd >> 5) & 1;
        if ((wd & 31) != 0) begin
          if (busy) rej = 1;
          else begin
            pick = 0;
            for (int i = 4; i >= 0; i--) if ((wd >> i) & 1) pick = i;
            m_cmd = 1 << pick;
            m_op = (pick == 0) ? 1 : (pick == 1) ? 2 : (pick == 2) ? 3 :
                   (pick == 3) ? 5 : 6;
            m_ackb = (wd >> 5) & 1;
            m_q = 0; m_bit = 0; m_rxf = 0;
          end
        end
      end
      if (buf_wr) begin
        if (!busy && !(ctrl_wr && (wd & 31) != 0)) begin
          m_op = 4; m_tx = buf_wdata; m_buf = buf_wdata;
          m_q = 0; m_bit = 0; m_rxf = 0;
        end else rej = 1;
      end
      m_irq = done; m_wcol = rej;
      l = 0;
    end
  end

  always @(negedge clk) begin : compare
    int lv, pull;
    if (rst_n) begin
      lv = (m_op != 0) ? lvl(m_op, m_q, cur_bit()) : m_hold;
      chk(bus_tag(m_op), {31'd0, scl_oe}, (lv >> 1) ? 0 : 1);
      chk(bus_tag(m_op), {31'd0, sda_oe}, (lv & 1) ? 0 : 1);
      chk("R8", {24'd0, ctrl_q},
          (m_gcen << 7) | (m_ackst << 6) | (m_ackdt << 5) | m_cmd);
      chk("R6", {24'd0, buf_q}, m_buf);
      chk("R6", {31'd0, rx_full}, m_rxf);
      chk("R11", {31'd0, irq}, m_irq);
      chk("R9", {31'd0, wcol}, m_wcol);
      chk("R12", {31'd0, gc_hit}, m_gc);
      if (irq) irq_seen++;
      if (gc_hit) gc_seen++;
    end
    pull = 0;
    if (m_op == 4 && m_bit == 8) pull = slv_ack_low;
    if (m_op == 5) pull = !((slv_byte >> (7 - m_bit)) & 1);
    sda_drv = (sda_oe || pull) ? 1'b0 : 1'b1;
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_wr = 1'b1; buf_wdata = v;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_op != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", {24'd0, ctrl_q}, 0);
    chk("R1", {24'd0, buf_q}, 0);
    chk("R1", {26'd0, scl_oe, sda_oe, irq, wcol, rx_full, gc_hit}, 0);
    rst_n = 1'b1;
    wr_ctrl(8'h01);
    wait_idle();
    chk("R2", {30'd0, scl_oe, sda_oe}, 3);
    slv_ack_low = 1;
    wr_buf(8'hA5);
    repeat (10) @(negedge clk);
    wr_buf(8'h11);
    wr_ctrl(8'h84);
    chk("R13", {31'd0, ctrl_q[7]}, 1);
    chk("R9", {31'd0, ctrl_q[2]}, 0);
    wait_idle();
    chk("R5", {24'd0, buf_q}, 8'hA5);
    chk("R5", {31'd0, ctrl_q[6]}, 0);
    slv_ack_low = 0;
    wr_buf(8'h3C);
    wait_idle();
    chk("R5", {31'd0, ctrl_q[6]}, 1);
    wr_ctrl(8'h82);
    wait_idle();
    slv_byte = 8'h5B;
    wr_ctrl(8'h88);
    wait_idle();
    chk("R6", {24'd0, buf_q}, 8'h5B);
    chk("R6", {30'd0, rx_full, ctrl_q[3]}, 2);
    wr_ctrl(8'h90);
    wait_idle();
    slv_byte = 8'h00;
    wr_ctrl(8'h88);
    wait_idle();
    chk("R12", gc_seen, 1);
    wr_ctrl(8'hB0);
    wait_idle();
    chk("R7", {31'd0, ctrl_q[5]}, 1);
    wr_ctrl(8'h8C);
    chk("R10", {27'd0, ctrl_q[4:0]}, 5'b00100);
    wait_idle();
    chk("R4", {30'd0, scl_oe, sda_oe}, 0);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = 8'h01; buf_wr = 1'b1; buf_wdata = 8'h77;
    @(negedge clk);
    ctrl_wr = 1'b0; buf_wr = 1'b0;
    chk("R9", {24'd0, buf_q}, 8'h00);
    wait_idle();
    wr_ctrl(8'h04);
    wait_idle();
    chk("R11", irq_seen, 11);
    finish_run();
  end
endmodule